// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Condition Flags

This block is a purely combinational integer ALU of parameterizable width (32 bits by default). It is built from a row of identical one-bit slices. Every slice works out AND, OR, XOR and the full-adder sum of its operand bits in parallel, and a four-way selector picks one of them as the result bit. The slices are chained through a ripple carry, and that carry is always computed, whatever operation is selected.

A small front-end decoder turns a 6-bit register-register function code into the two internal controls: a 2-bit operation select and a subtract enable. Subtraction reuses the adder. Every B bit is inverted by the subtract enable, and the same bit enters as the carry-in of slice 0.

Four condition flags come with the result:
- zero, which describes the selected result;
- sign, which also describes the selected result;
- carry, which reports the adder chain in the not-borrow sense for subtraction;
- overflow, which is signed two's-complement overflow taken from the carries around the sign bit.

A function code that the decoder does not recognise falls back to add and raises an illegal-code output.

Top module: `bitslice_alu`

## Requirements
- R1: The function code selects the operation. 0x20 is add, 0x22 is subtract, 0x24 is AND, 0x25 is OR and 0x26 is XOR. Internally the select encodings are 00 = AND, 01 = OR, 10 = XOR and 11 = adder sum.
- R2: For AND, OR and XOR, `result` is the bitwise function of `a` and `b`.
- R3: For add, `result` equals (a + b) mod 2^WIDTH.
- R4: For subtract, `result` equals (a − b) mod 2^WIDTH, formed as a + ~b + 1.
- R5: `flag_c` is the carry out of the most significant slice. After add, 1 means the unsigned sum wrapped. After subtract, 1 means no borrow: 0101−0011 gives C = 1 and 0011−0101 gives C = 0.
- R6: `flag_v` is the carry into the sign bit XOR the carry out of it, which equals signed overflow of the effective addition. 0111+0001 gives V = 1 and C = 0. 1111+0001 gives V = 0 and C = 1.
- R7: `flag_z` is 1 exactly when every result bit is 0. `flag_n` equals result bit WIDTH−1.
- R8: For AND, OR and XOR, `flag_c` and `flag_v` still report the adder chain for a + b with carry-in 0.
- R9: Any function code other than the five listed drives `illegal_funct` = 1 and behaves exactly as add. The five listed codes drive `illegal_funct` = 0.
- R10: R1 to R9 hold for every WIDTH of 2 or more, including 4, 8 and 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| funct | input | 6 | Register-register function code |
| result | output | WIDTH | Selected result |
| flag_z | output | 1 | Result is all zeros |
| flag_n | output | 1 | Top bit of result |
| flag_c | output | 1 | Carry out of top slice (not-borrow on subtract) |
| flag_v | output | 1 | Signed overflow of the adder chain |
| illegal_funct | output | 1 | Function code not recognised; add performed |

## Verification
The bench sweeps every operand pair at 4 bits (under all 64 function codes) and at 8 bits (under the five legal codes), and runs random vectors at 32 bits. A reference model computes a ± b in WIDTH+1 bits and derives overflow from the operand and result signs. It targets four mistakes:
- A design that uses carry-out as overflow fails the 0111+0001 and 1111+0001 cases.
- A design that reports carry as borrow on subtract inverts C on every subtraction.
- A design that forgets the carry-in of 1 is off by one on all subtracts.
- A design that clears C and V on logic operations, or mis-decodes an illegal code, is caught by the logic-operation and all-codes sweeps.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        SEL_AND = 2'b00,
        SEL_OR  = 2'b01,
        SEL_XOR = 2'b10,
        SEL_SUM = 2'b11
    } alu_sel_e;

    typedef struct packed {
        logic     sub;
        alu_sel_e sel;
        logic     illegal;
    } alu_ctrl_t;

    localparam int FUNCT_W = 6;

    localparam logic [FUNCT_W-1:0] FN_ADD = 6'h20;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'h22;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'h24;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'h25;
    localparam logic [FUNCT_W-1:0] FN_XOR = 6'h26;

    function automatic logic majority3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/alu_funct_decode.sv
module alu_funct_decode
    import alu_pkg::*;
(
    input  logic [FUNCT_W-1:0] funct,
    output alu_ctrl_t          ctrl
);

    always_comb begin
        ctrl = '{sub: 1'b0, sel: SEL_SUM, illegal: 1'b0};
        case (funct)
            FN_ADD:  ctrl = '{sub: 1'b0, sel: SEL_SUM, illegal: 1'b0};
            FN_SUB:  ctrl = '{sub: 1'b1, sel: SEL_SUM, illegal: 1'b0};
            FN_AND:  ctrl = '{sub: 1'b0, sel: SEL_AND, illegal: 1'b0};
            FN_OR:   ctrl = '{sub: 1'b0, sel: SEL_OR,  illegal: 1'b0};
            FN_XOR:  ctrl = '{sub: 1'b0, sel: SEL_XOR, illegal: 1'b0};
            default: ctrl = '{sub: 1'b0, sel: SEL_SUM, illegal: 1'b1};
        endcase
    end

    // Unrecognised codes must fall back to a plain add.
    always_comb begin
        if (ctrl.illegal) begin
            assert_illegal_is_add_R9: assert (ctrl.sel == SEL_SUM && !ctrl.sub)
                else $error("illegal code did not decode to add");
        end
    end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic     a_bit,
    input  logic     b_bit,
    input  logic     sub_en,
    input  logic     c_in,
    input  alu_sel_e sel,
    output logic     r_bit,
    output logic     c_out
);

    logic b_eff;
    logic cand_and, cand_or, cand_xor, cand_sum;

    assign b_eff    = b_bit ^ sub_en;
    assign cand_and = a_bit & b_eff;
    assign cand_or  = a_bit | b_eff;
    assign cand_xor = a_bit ^ b_eff;
    assign cand_sum = a_bit ^ b_eff ^ c_in;

    // Carry is produced whatever the selection.
    assign c_out = majority3(a_bit, b_eff, c_in);

    always_comb begin
        unique case (sel)
            SEL_AND: r_bit = cand_and;
            SEL_OR:  r_bit = cand_or;
            SEL_XOR: r_bit = cand_xor;
            SEL_SUM: r_bit = cand_sum;
        endcase
    end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] result,
    input  logic             carry_into_msb,
    input  logic             carry_out_msb,
    output logic             flag_z,
    output logic             flag_n,
    output logic             flag_c,
    output logic             flag_v
);

    localparam int MSB = WIDTH - 1;

    assign flag_z = ~|result;
    assign flag_n = result[MSB];
    assign flag_c = carry_out_msb;
    assign flag_v = carry_into_msb ^ carry_out_msb;

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    input  logic [FUNCT_W-1:0] funct,
    output logic [WIDTH-1:0]   result,
    output logic               flag_z,
    output logic               flag_n,
    output logic               flag_c,
    output logic               flag_v,
    output logic               illegal_funct
);

    localparam int MSB  = WIDTH - 1;
    localparam int EXTW = WIDTH + 1;

    alu_ctrl_t        ctrl;
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] b_inv;

    alu_funct_decode u_decode (
        .funct (funct),
        .ctrl  (ctrl)
    );

    assign chain[0]      = ctrl.sub;
    assign illegal_funct = ctrl.illegal;
    assign b_inv         = b ^ {WIDTH{ctrl.sub}};

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_slice u_slice (
            .a_bit  (a[i]),
            .b_bit  (b[i]),
            .sub_en (ctrl.sub),
            .c_in   (chain[i]),
            .sel    (ctrl.sel),
            .r_bit  (result[i]),
            .c_out  (chain[i+1])
        );
    end

    alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
        .result         (result),
        .carry_into_msb (chain[MSB]),
        .carry_out_msb  (chain[WIDTH]),
        .flag_z         (flag_z),
        .flag_n         (flag_n),
        .flag_c         (flag_c),
        .flag_v         (flag_v)
    );

    always_comb begin
        if (ctrl.sel == SEL_SUM) begin
            // Arithmetic view of the slice chain, wide enough to keep the carry.
            assert_sum_carry_R5: assert ({flag_c, result} ==
                    ({1'b0, a} + {1'b0, b_inv} + EXTW'(ctrl.sub)))
                else $error("carry/sum disagree with wide addition");
            // Sign-rule overflow against the carry-pair overflow.
            assert_no_overflow_R6: assert (flag_v ==
                    ((a[MSB] == b_inv[MSB]) && (result[MSB] != a[MSB])))
                else $error("overflow flag disagrees with sign rule");
        end
        if (ctrl.sub && (a == b)) begin
            assert_equal_diff_R4: assert (flag_z && flag_c)
                else $error("x - x must be zero with no borrow");
        end
    end

endmodule

// File: tb/bitslice_alu_test.sv
`timescale 1ns/100ps
module bitslice_alu_test;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    // Instances at 8 (uut), 4 and 32 bits (R10)
    logic [7:0]  a8, b8, r8;
    logic [3:0]  a4, b4, r4;
    logic [31:0] a32, b32, r32;
    logic [5:0]  f8, f4, f32;
    logic z8, n8, c8, v8, i8;
    logic z4, n4, c4, v4, i4;
    logic z32, n32, c32, v32, i32;

    bitslice_alu #(.WIDTH(8)) uut (
        .a(a8), .b(b8), .funct(f8), .result(r8),
        .flag_z(z8), .flag_n(n8), .flag_c(c8), .flag_v(v8), .illegal_funct(i8));
    bitslice_alu #(.WIDTH(4)) uut_w4 (
        .a(a4), .b(b4), .funct(f4), .result(r4),
        .flag_z(z4), .flag_n(n4), .flag_c(c4), .flag_v(v4), .illegal_funct(i4));
    bitslice_alu #(.WIDTH(32)) uut_w32 (
        .a(a32), .b(b32), .funct(f32), .result(r32),
        .flag_z(z32), .flag_n(n32), .flag_c(c32), .flag_v(v32), .illegal_funct(i32));

    typedef struct packed {
        logic        ill;
        logic        v;
        logic        c;
        logic        n;
        logic        z;
        logic [31:0] res;
    } obs_t;

    // Reference: wide arithmetic, overflow from operand/result signs.
    function automatic obs_t ref_model(int w, logic [31:0] a, logic [31:0] b, logic [5:0] f);
        obs_t   o;
        longint mask, ua, ub, s, sum;
        logic   sub;
        logic [31:0] res;
        o.ill = !(f == 6'h20 || f == 6'h22 || f == 6'h24 || f == 6'h25 || f == 6'h26);
        sub  = (f == 6'h22);
        mask = (64'd1 << w) - 64'd1;
        ua   = longint'(a) & mask;
        ub   = (sub ? ~longint'(b) : longint'(b)) & mask;
        s    = ua + ub + (sub ? 64'd1 : 64'd0);
        sum  = s & mask;
        o.c  = s[w];
        o.v  = (ua[w-1] == ub[w-1]) && (sum[w-1] != ua[w-1]);
        case (f)
            6'h24:   res = a & b;
            6'h25:   res = a | b;
            6'h26:   res = a ^ b;
            default: res = sum[31:0];
        endcase
        res   = res & mask[31:0];
        o.res = res;
        o.z   = (res == 32'd0);
        o.n   = res[w-1];
        return o;
    endfunction

    function automatic string op_tag(logic [5:0] f);
        case (f)
            6'h20:   return "R3";
            6'h22:   return "R4";
            6'h24, 6'h25, 6'h26: return "R2";
            default: return "R9";
        endcase
    endfunction

    task automatic apply(int w, logic [31:0] a, logic [31:0] b, logic [5:0] f, output obs_t got);
        case (w)
            4:       begin a4 = a[3:0]; b4 = b[3:0]; f4 = f; end
            8:       begin a8 = a[7:0]; b8 = b[7:0]; f8 = f; end
            default: begin a32 = a; b32 = b; f32 = f; end
        endcase
        #1;
        case (w)
            4:       got = '{ill: i4, v: v4, c: c4, n: n4, z: z4, res: {28'd0, r4}};
            8:       got = '{ill: i8, v: v8, c: c8, n: n8, z: z8, res: {24'd0, r8}};
            default: got = '{ill: i32, v: v32, c: c32, n: n32, z: z32, res: r32};
        endcase
    endtask

    task automatic check_vec(int w, logic [31:0] a, logic [31:0] b, logic [5:0] f);
        obs_t got, exp;
        bit   logic_op;
        apply(w, a, b, f, got);
        exp      = ref_model(w, a, b, f);
        logic_op = (f == 6'h24 || f == 6'h25 || f == 6'h26);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            if (got.res != exp.res)
                $display("FAIL %s/R1/R10 w=%0d f=%h a=%h b=%h result got=%h exp=%h",
                         op_tag(f), w, f, a, b, got.res, exp.res);
            if (got.c != exp.c)
                $display("FAIL %s w=%0d f=%h a=%h b=%h C got=%b exp=%b",
                         logic_op ? "R8" : "R5", w, f, a, b, got.c, exp.c);
            if (got.v != exp.v)
                $display("FAIL %s w=%0d f=%h a=%h b=%h V got=%b exp=%b",
                         logic_op ? "R8" : "R6", w, f, a, b, got.v, exp.v);
            if (got.z != exp.z || got.n != exp.n)
                $display("FAIL R7 w=%0d f=%h a=%h b=%h ZN got=%b%b exp=%b%b",
                         w, f, a, b, got.z, got.n, exp.z, exp.n);
            if (got.ill != exp.ill)
                $display("FAIL R9 w=%0d f=%h illegal got=%b exp=%b", w, f, got.ill, exp.ill);
        end
    endtask

    // Literal worked examples, independent of the reference model.
    task automatic check_lit(string tag, logic [3:0] a, logic [3:0] b, logic [5:0] f,
                             logic [3:0] er, logic ec, logic ev);
        obs_t got;
        apply(4, {28'd0, a}, {28'd0, b}, f, got);
        n_checks++;
        if (got.res[3:0] != er || got.c != ec || got.v != ev) begin
            n_errors++;
            $display("FAIL %s a=%b b=%b got r=%b c=%b v=%b exp r=%b c=%b v=%b",
                     tag, a, b, got.res[3:0], got.c, got.v, er, ec, ev);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 180000) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    initial begin
        logic [5:0] legal [5];
        legal = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26};
        a4 = '0; b4 = '0; f4 = 6'h20;
        a8 = '0; b8 = '0; f8 = 6'h20;
        a32 = '0; b32 = '0; f32 = 6'h20;
        #0.3;

        // Quiet state: 0 + 0 gives zero set, no carry, no overflow (R7)
        check_vec(32, 32'd0, 32'd0, 6'h20);

        // R5: subtract carry as not-borrow
        check_lit("R5 0101-0011", 4'b0101, 4'b0011, 6'h22, 4'b0010, 1'b1, 1'b0);
        check_lit("R5 0011-0101", 4'b0011, 4'b0101, 6'h22, 4'b1110, 1'b0, 1'b0);
        // R6: overflow is not carry
        check_lit("R6 0111+0001", 4'b0111, 4'b0001, 6'h20, 4'b1000, 1'b0, 1'b1);
        check_lit("R6 1111+0001", 4'b1111, 4'b0001, 6'h20, 4'b0000, 1'b1, 1'b0);
        check_lit("R4 1000-0001", 4'b1000, 4'b0001, 6'h22, 4'b0111, 1'b1, 1'b1);
        // R8: logic op still reports the add chain (0111 AND 0001, chain overflows)
        check_lit("R8 and", 4'b0111, 4'b0001, 6'h24, 4'b0001, 1'b0, 1'b1);
        // R9: illegal code acts as add
        check_lit("R9 funct 3f", 4'b0111, 4'b0001, 6'h3f, 4'b1000, 1'b0, 1'b1);

        // R1/R9/R10: exhaustive 4-bit over every function code
        for (int f = 0; f < 64; f++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    check_vec(4, 32'(a), 32'(b), 6'(f));

        // R2-R8: exhaustive 8-bit over the legal codes
        foreach (legal[k])
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    check_vec(8, 32'(a), 32'(b), legal[k]);

        // R10: 32-bit corners and random vectors
        foreach (legal[k]) begin
            check_vec(32, 32'h7fffffff, 32'h00000001, legal[k]);
            check_vec(32, 32'h80000000, 32'h00000001, legal[k]);
            check_vec(32, 32'hffffffff, 32'hffffffff, legal[k]);
            check_vec(32, 32'h12345678, 32'h12345678, legal[k]);
            for (int j = 0; j < 2000; j++)
                check_vec(32, $urandom, $urandom, legal[k]);
        end
        for (int j = 0; j < 200; j++)
            check_vec(32, $urandom, $urandom, 6'($urandom));

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule